// File: doc/BRIEF.md
# Big-Endian Block Transfer FIFO

This block is a 512-byte staging buffer between a host bus and a byte-serial card engine. The host sees it as a 32-bit word port with big-endian byte order: the first byte on the card side is the most significant byte of the word. Host words arrive or leave through either a programmed-IO strobe pair or a DMA word port. The DMA port is only honoured when the programmed transfer length is a full 512-byte block. The card side is a plain byte stream with a push strobe and a pop strobe.

One direction bit selects which side fills the buffer. With the bit high, the host writes and the card drains. With it low, the card fills and the host reads. The block keeps a byte count and drives an empty output that the host checks before it starts a transfer. It also keeps two sticky error flags. The underrun flag records a host read of an empty buffer. The mismatch flag records that, at the transfer-end strobe, the byte count differed from the programmed length.

Top module: `be_block_fifo`

## Requirements
- R1: The buffer holds at most 512 bytes, and byte_count never exceeds 512. A card byte pushed while 512 bytes are held is dropped. A programmed length above 512 acts as 512.
- R2: A programmed-IO host write of a full word stores its bytes so that the card pops bits 31:24 first, then 23:16, then 15:8, then 7:0.
- R3: When 4 or more bytes are held, a host read returns the oldest byte in bits 31:24 and the next three bytes below it in arrival order, and it removes 4 bytes.
- R4: A host write stores only as many bytes as fit between byte_count and the programmed length (at most 4), taken from the most significant end of the word. The remaining low-order pad bytes are discarded.
- R5: When k bytes are held with 0 < k < 4, a host read returns them in the k low-order byte lanes, oldest most significant among them, with zero above. It removes all k bytes.
- R6: The DMA write and read ports act only while the effective length equals 512. Otherwise a DMA write leaves byte_count unchanged, and a DMA read returns zero and removes nothing.
- R7: A programmed-IO host read in card-to-host direction while byte_count is zero returns zero, leaves the count at zero and sets the sticky underrun flag.
- R8: At the transfer-end strobe the sticky mismatch flag is set if byte_count differs from the effective length. It stays clear when the two are equal.
- R9: With direction bit 1 (host-to-card), host writes and card pops are accepted, while card pushes and host reads have no effect. With direction bit 0 (card-to-host), card pushes and host reads are accepted, while host writes and card pops have no effect.
- R10: The empty output is high exactly when byte_count is zero.
- R11: A synchronous active-high reset clears byte_count and both flags, and raises empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_to_card | input | 1 | 1: host fills, card drains; 0: card fills, host reads |
| xfer_len | input | 10 | Programmed transfer length in bytes (saturates at 512) |
| xfer_end | input | 1 | Transfer-end strobe, compares count with length |
| pio_wr | input | 1 | Programmed-IO word write strobe |
| pio_wdata | input | 32 | Programmed-IO write word, big-endian |
| pio_rd | input | 1 | Programmed-IO word read strobe |
| pio_rdata | output | 32 | Word returned while pio_rd is accepted, else zero |
| dma_wr | input | 1 | DMA word write strobe |
| dma_wdata | input | 32 | DMA write word, big-endian |
| dma_rd | input | 1 | DMA word read strobe |
| dma_rdata | output | 32 | Word returned while dma_rd is accepted, else zero |
| card_push | input | 1 | Card-side byte push strobe |
| card_din | input | 8 | Card-side byte in |
| card_pop | input | 1 | Card-side byte pop strobe |
| card_dout | output | 8 | Oldest held byte |
| byte_count | output | 10 | Bytes currently held |
| empty | output | 1 | High when no byte is held |
| underrun | output | 1 | Sticky host-read-of-empty flag |
| mismatch | output | 1 | Sticky length-mismatch flag |

## Verification
A corrupt read or write pointer shows up on the next word read or card pop. The bytes come out rotated or stale, so the first compare of pio_rdata or card_dout after the fault exposes it. A count that drifts from the pointers shows at once on byte_count and empty. It also shows later as a false mismatch at the next transfer-end strobe, or as a missing or spurious underrun. Direction and length gating errors change byte_count one cycle after the ignored strobe, so every operation is followed by a comparison of count, empty and both flags.

// File: rtl/be_fifo_pkg.sv
package be_fifo_pkg;

    localparam int unsigned FIFO_BYTES = 512;
    localparam int unsigned LANES      = 4;
    localparam int unsigned LANE_CNT_W = $clog2(LANES) + 1;

    typedef logic [7:0]              byte_t;
    typedef logic [LANES-1:0][7:0]   lanes_t;
    typedef logic [LANES*8-1:0]      word_t;
    typedef logic [LANE_CNT_W-1:0]   lane_cnt_t;

    typedef enum logic {
        DIR_TO_HOST = 1'b0,
        DIR_TO_CARD = 1'b1
    } xfer_dir_e;

    // Bytes entering the store in one cycle; lane 0 is the oldest.
    typedef struct packed {
        lane_cnt_t n;
        lanes_t    lanes;
    } burst_t;

    // Big-endian word to lanes: lane 0 takes the most significant byte.
    function automatic lanes_t split_be(word_t w);
        lanes_t r;
        for (int i = 0; i < LANES; i++) begin
            r[i] = w[(LANES-1-i)*8 +: 8];
        end
        return r;
    endfunction

    // First n lanes packed into the low-order end, oldest most significant.
    function automatic word_t join_low(lanes_t b, lane_cnt_t n);
        word_t w;
        w = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_cnt_t'(i) < n) begin
                w = {w[LANES*8-9:0], b[i]};
            end
        end
        return w;
    endfunction

    function automatic lane_cnt_t clip_lanes(int unsigned avail);
        return (avail >= LANES) ? lane_cnt_t'(LANES) : lane_cnt_t'(avail);
    endfunction

endpackage

// File: rtl/be_byte_store.sv
module be_byte_store
    import be_fifo_pkg::*;
#(
    parameter  int unsigned DEPTH = FIFO_BYTES,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic [PTR_W-1:0] wr_ptr,
    input  burst_t           wr_burst,
    input  logic [PTR_W-1:0] rd_ptr,
    output lanes_t           rd_lanes
);

    byte_t mem [DEPTH];

    // Up to LANES consecutive bytes per cycle; addresses wrap modulo DEPTH.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (lane_cnt_t'(i) < wr_burst.n) begin
                mem[wr_ptr + PTR_W'(i)] <= wr_burst.lanes[i];
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_rd_lane
        assign rd_lanes[g] = mem[rd_ptr + PTR_W'(g)];
    end

endmodule

// File: rtl/be_occupancy.sv
module be_occupancy
    import be_fifo_pkg::*;
#(
    parameter  int unsigned DEPTH = FIFO_BYTES,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  lane_cnt_t        n_in,
    input  lane_cnt_t        n_out,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(n_in);
            rd_ptr <= rd_ptr + PTR_W'(n_out);
            count  <= count + CNT_W'(n_in) - CNT_W'(n_out);
        end
    end

endmodule

// File: rtl/be_flag_unit.sv
module be_flag_unit (
    input  logic clk,
    input  logic rst,
    input  logic underrun_evt,
    input  logic end_evt,
    input  logic len_match,
    output logic underrun,
    output logic mismatch
);

    always_ff @(posedge clk) begin
        if (rst) begin
            underrun <= 1'b0;
            mismatch <= 1'b0;
        end else begin
            if (underrun_evt) begin
                underrun <= 1'b1;
            end
            if (end_evt && !len_match) begin
                mismatch <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/be_block_fifo.sv
module be_block_fifo
    import be_fifo_pkg::*;
#(
    parameter  int unsigned DEPTH = FIFO_BYTES,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dir_to_card,
    input  logic [CNT_W-1:0] xfer_len,
    input  logic             xfer_end,
    input  logic             pio_wr,
    input  logic [31:0]      pio_wdata,
    input  logic             pio_rd,
    output logic [31:0]      pio_rdata,
    input  logic             dma_wr,
    input  logic [31:0]      dma_wdata,
    input  logic             dma_rd,
    output logic [31:0]      dma_rdata,
    input  logic             card_push,
    input  logic [7:0]       card_din,
    input  logic             card_pop,
    output logic [7:0]       card_dout,
    output logic [CNT_W-1:0] byte_count,
    output logic             empty,
    output logic             underrun,
    output logic             mismatch
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    xfer_dir_e        dir;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] len_eff;
    logic [CNT_W-1:0] room;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    lane_cnt_t        host_n;
    lane_cnt_t        avail_n;
    lane_cnt_t        n_out;
    burst_t           in_burst;
    lanes_t           head_lanes;
    word_t            wr_word;
    word_t            peek_word;
    logic             block_len;
    logic             host_wr_go;
    logic             pio_rd_go;
    logic             dma_rd_go;
    logic             under_evt;
    logic             len_match;

    assign dir = xfer_dir_e'(dir_to_card);

    // Length, room and lane counts.
    always_comb begin
        len_eff   = (xfer_len > FULL_CNT) ? FULL_CNT : xfer_len;
        block_len = (len_eff == FULL_CNT);
        room      = (len_eff > count) ? (len_eff - count) : '0;
        host_n    = clip_lanes(32'(room));
        avail_n   = clip_lanes(32'(count));
        len_match = (count == len_eff);
    end

    // Which side may move bytes this cycle.
    always_comb begin
        host_wr_go = (dir == DIR_TO_CARD) && (pio_wr || (dma_wr && block_len));
        wr_word    = pio_wr ? pio_wdata : dma_wdata;
        pio_rd_go  = (dir == DIR_TO_HOST) && pio_rd;
        dma_rd_go  = (dir == DIR_TO_HOST) && dma_rd && block_len && !pio_rd;
        under_evt  = pio_rd_go && (count == '0);
    end

    // Ingress: host words toward the card, or card bytes toward the host.
    always_comb begin
        in_burst = '0;
        if (dir == DIR_TO_CARD) begin
            if (host_wr_go) begin
                in_burst.n     = host_n;
                in_burst.lanes = split_be(wr_word);
            end
        end else if (card_push && (count < FULL_CNT)) begin
            in_burst.n        = lane_cnt_t'(1);
            in_burst.lanes[0] = card_din;
        end
    end

    // Egress: card pops one byte, host reads up to one word.
    always_comb begin
        n_out = '0;
        if (dir == DIR_TO_CARD) begin
            if (card_pop && (count != '0)) begin
                n_out = lane_cnt_t'(1);
            end
        end else if (pio_rd_go || dma_rd_go) begin
            n_out = avail_n;
        end
    end

    assign peek_word = join_low(head_lanes, avail_n);

    be_byte_store #(.DEPTH(DEPTH)) i_store (
        .clk      (clk),
        .wr_ptr   (wr_ptr),
        .wr_burst (in_burst),
        .rd_ptr   (rd_ptr),
        .rd_lanes (head_lanes)
    );

    be_occupancy #(.DEPTH(DEPTH)) i_occ (
        .clk    (clk),
        .rst    (rst),
        .n_in   (in_burst.n),
        .n_out  (n_out),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .count  (count)
    );

    be_flag_unit i_flags (
        .clk          (clk),
        .rst          (rst),
        .underrun_evt (under_evt),
        .end_evt      (xfer_end),
        .len_match    (len_match),
        .underrun     (underrun),
        .mismatch     (mismatch)
    );

    assign pio_rdata  = pio_rd_go ? peek_word : '0;
    assign dma_rdata  = dma_rd_go ? peek_word : '0;
    assign card_dout  = head_lanes[0];
    assign byte_count = count;
    assign empty      = (count == '0);

endmodule

// File: rtl/be_block_fifo_chk.sv
module be_block_fifo_chk #(
    parameter  int unsigned DEPTH = 512,
    localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             dir_to_card,
    input logic [CNT_W-1:0] xfer_len,
    input logic             xfer_end,
    input logic             pio_wr,
    input logic             pio_rd,
    input logic             dma_wr,
    input logic             card_push,
    input logic             card_pop,
    input logic [CNT_W-1:0] byte_count,
    input logic             empty,
    input logic             underrun,
    input logic             mismatch
);

    int len_sat;
    int cnt_i;
    always_comb begin
        len_sat = (int'(xfer_len) > int'(DEPTH)) ? int'(DEPTH) : int'(xfer_len);
        cnt_i   = int'(byte_count);
    end

    p_count_cap_r1: assert property (@(posedge clk) disable iff (rst)
        cnt_i <= int'(DEPTH));

    // R2 and R4: a full word of room means exactly four bytes enter.
    p_word_adds_four_r4: assert property (@(posedge clk) disable iff (rst)
        dir_to_card && pio_wr && !card_pop && (len_sat >= cnt_i + 4)
        |=> int'(byte_count) == int'($past(byte_count)) + 4);

    p_dma_gated_r6: assert property (@(posedge clk) disable iff (rst)
        dir_to_card && dma_wr && !pio_wr && !card_pop && (len_sat != int'(DEPTH))
        |=> $stable(byte_count));

    p_underrun_set_r7: assert property (@(posedge clk) disable iff (rst)
        !dir_to_card && pio_rd && empty |=> underrun);

    p_underrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);

    p_mismatch_set_r8: assert property (@(posedge clk) disable iff (rst)
        xfer_end && (cnt_i != len_sat) |=> mismatch);

    p_mismatch_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        mismatch |=> mismatch);

    p_card_push_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        dir_to_card && card_push && !pio_wr && !dma_wr && !card_pop
        |=> $stable(byte_count));

    p_empty_holds_r10: assert property (@(posedge clk) disable iff (rst)
        empty && !card_push && !pio_wr && !dma_wr |=> empty);

    p_reset_clears_r11: assert property (@(posedge clk)
        rst |=> (byte_count == '0) && empty && !underrun && !mismatch);

endmodule

bind be_block_fifo be_block_fifo_chk #(.DEPTH(DEPTH)) i_be_chk (
    .clk         (clk),
    .rst         (rst),
    .dir_to_card (dir_to_card),
    .xfer_len    (xfer_len),
    .xfer_end    (xfer_end),
    .pio_wr      (pio_wr),
    .pio_rd      (pio_rd),
    .dma_wr      (dma_wr),
    .card_push   (card_push),
    .card_pop    (card_pop),
    .byte_count  (byte_count),
    .empty       (empty),
    .underrun    (underrun),
    .mismatch    (mismatch)
);

// File: tb/test_be_block_fifo.sv
module test_be_block_fifo;

    localparam int DEPTH = 512;
    localparam int CNT_W = 10;

    logic             clk = 1'b0;
    logic             rst;
    logic             dir_to_card;
    logic [CNT_W-1:0] xfer_len;
    logic             xfer_end;
    logic             pio_wr;
    logic [31:0]      pio_wdata;
    logic             pio_rd;
    logic [31:0]      pio_rdata;
    logic             dma_wr;
    logic [31:0]      dma_wdata;
    logic             dma_rd;
    logic [31:0]      dma_rdata;
    logic             card_push;
    logic [7:0]       card_din;
    logic             card_pop;
    logic [7:0]       card_dout;
    logic [CNT_W-1:0] byte_count;
    logic             empty;
    logic             underrun;
    logic             mismatch;

    always #10 clk = ~clk;

    be_block_fifo i_be_block_fifo (.*);

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 0;
    logic [7:0] q[$];
    bit   m_under;
    bit   m_mis;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int len_eff();
        return (int'(xfer_len) > DEPTH) ? DEPTH : int'(xfer_len);
    endfunction

    task automatic settle_state(string req);
        chk(req, "byte_count", 32'(byte_count), 32'(q.size()));
        chk(req, "empty",      32'(empty),      32'(q.size() == 0));
        chk(req, "underrun",   32'(underrun),   32'(m_under));
        chk(req, "mismatch",   32'(mismatch),   32'(m_mis));
    endtask

    task automatic finish_cycle();
        @(posedge clk);
        @(negedge clk);
        pio_wr = 0; pio_rd = 0; dma_wr = 0; dma_rd = 0;
        card_push = 0; card_pop = 0; xfer_end = 0;
    endtask

    task automatic do_reset();
        rst = 1;
        finish_cycle();
        finish_cycle();
        rst = 0;
        q.delete();
        m_under = 0;
        m_mis = 0;
        settle_state("R11");
    endtask

    task automatic host_write(bit use_dma, logic [31:0] w, string req);
        if (use_dma) begin dma_wr = 1; dma_wdata = w; end
        else begin pio_wr = 1; pio_wdata = w; end
        if (dir_to_card && (!use_dma || len_eff() == DEPTH)) begin
            int room = len_eff() - q.size();
            int n = (room < 0) ? 0 : ((room > 4) ? 4 : room);
            for (int i = 0; i < n; i++) q.push_back(w[31-8*i -: 8]);
        end
        finish_cycle();
        settle_state(req);
    endtask

    task automatic host_read(bit use_dma, string req);
        logic [31:0] exp;
        bit acc;
        int k;
        if (use_dma) dma_rd = 1; else pio_rd = 1;
        #2;
        acc = !dir_to_card && (!use_dma || len_eff() == DEPTH);
        exp = '0;
        k = 0;
        if (acc) begin
            k = (q.size() > 4) ? 4 : q.size();
            for (int i = 0; i < k; i++) exp = {exp[23:0], q[i]};
            if (!use_dma && q.size() == 0) m_under = 1;
        end
        chk(req, "rdata", use_dma ? dma_rdata : pio_rdata, exp);
        for (int i = 0; i < k; i++) void'(q.pop_front());
        finish_cycle();
        settle_state(req);
    endtask

    task automatic card_put(logic [7:0] b, string req);
        card_push = 1;
        card_din = b;
        if (!dir_to_card && q.size() < DEPTH) q.push_back(b);
        finish_cycle();
        settle_state(req);
    endtask

    task automatic card_take(string req);
        card_pop = 1;
        #2;
        if (dir_to_card && q.size() > 0) begin
            chk(req, "card_dout", 32'(card_dout), 32'(q[0]));
            void'(q.pop_front());
        end
        finish_cycle();
        settle_state(req);
    endtask

    task automatic end_xfer(string req);
        xfer_end = 1;
        if (q.size() != len_eff()) m_mis = 1;
        finish_cycle();
        settle_state(req);
    endtask

    task automatic report();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        rst = 1; dir_to_card = 1; xfer_len = '0; xfer_end = 0;
        pio_wr = 0; pio_wdata = '0; pio_rd = 0; dma_wr = 0; dma_wdata = '0;
        dma_rd = 0; card_push = 0; card_din = '0; card_pop = 0;
        void'($urandom(32'd2024));
        repeat (2) @(negedge clk);
        rst = 0;
        m_under = 0; m_mis = 0;
        settle_state("R11");            // reset state, R10 empty high

        // R2/R4: host-to-card, length 6, second word partly padding
        dir_to_card = 1; xfer_len = 10'd6;
        host_write(0, 32'hA1B2C3D4, "R2");
        host_write(0, 32'h11223344, "R4");
        end_xfer("R8");                 // 6 held vs 6: stays clear
        card_put(8'h5A, "R9");          // card push ignored while host-to-card
        host_write(1, 32'hDEADBEEF, "R6"); // DMA ignored for short length
        host_read(0, "R9");             // host read ignored, no underrun
        for (int i = 0; i < 6; i++) card_take("R2");
        card_take("R10");

        // R3/R5/R7: card-to-host, length 7
        dir_to_card = 0; xfer_len = 10'd7;
        for (int i = 1; i <= 7; i++) card_put(8'(i), "R9");
        host_write(0, 32'h01010101, "R9"); // host write ignored
        card_take("R9");                // card pop ignored
        host_read(1, "R6");             // DMA read gated off
        host_read(0, "R3");
        host_read(0, "R5");
        host_read(0, "R7");
        end_xfer("R8");                 // 0 vs 7: mismatch
        do_reset();

        // R1/R6: saturated length acts as one full block over DMA
        dir_to_card = 1; xfer_len = 10'd600;
        for (int i = 0; i < 128; i++) host_write(1, {8'(i), 8'(~i), 8'(i*3), 8'(i+7)}, "R6");
        host_write(1, 32'hFFFFFFFF, "R1");
        end_xfer("R8");
        for (int i = 0; i < 512; i++) card_take("R2");

        dir_to_card = 0; xfer_len = 10'd512;
        for (int i = 0; i < 513; i++) card_put(8'(i * 7 + 1), "R1");
        for (int i = 0; i < 128; i++) host_read(1, "R3");
        host_read(0, "R7");
        do_reset();

        // Constrained random mix
        for (int it = 0; it < 4000; it++) begin
            int r = int'($urandom % 16);
            case (r)
                0: dir_to_card = ~dir_to_card;
                1: xfer_len = ($urandom % 3 == 0) ? 10'd512 : 10'($urandom % 700);
                2: if ($urandom % 8 == 0) do_reset();
                3, 4, 5: host_write(0, $urandom, "R4");
                6: host_write(1, $urandom, "R6");
                7, 8, 9: host_read(0, "R5");
                10: host_read(1, "R6");
                11, 12: card_put(8'($urandom), "R9");
                13, 14: card_take("R2");
                default: end_xfer("R8");
            endcase
        end
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            report();
        end
    end

endmodule